// File: doc/BRIEF.md
# Power Domain and Module Sleep Controller

A register-mapped controller that sequences power domains and the clock and reset state of the modules inside them. Software writes a target state into a module's control word. Writing that word alone does not move the module. The new state takes effect only when software writes the command register with the bit of the module's domain set. A per-domain sequencer then carries out the transition. The domain status word and the transition-busy bit report how it went.

When the target domain is still unpowered, the sequencer first raises that domain's bit on an external power request output and waits. It moves no module until software sets a power-good bit in the domain control word. Each module then changes state through a request/acknowledge handshake with its own logic, or at once if its force bit is set. A local reset bit in each module control word drives the module's reset pin directly, with no command.

With the default parameters there are 2 domains and 8 modules. Modules 0 to 3 belong to domain 0 and modules 4 to 7 to domain 1. In general, module m belongs to domain floor(m * N_DOM / N_MOD).

Top module: `pd_sleep_ctrl`

## Requirements
- R1: A read request on the bus (valid high, write low) produces read-valid on the following cycle, with the data of the addressed register. The byte addresses are: command 0x120, transition-busy 0x128, power request 0x1040, domain status 0x200+4d, domain control 0x300+4d, module status 0x800+4m, module control 0xA00+4m.
- R2: After reset, every module status word reads 0x100, every domain status word, the transition-busy register and the power request register read 0, and no module request is raised.
- R3: Writing a module's target state changes neither its status word nor its pins until a command for its domain is written.
- R4: Writing the command register with bit d set makes busy bit d read 1 until the transition is done, after which it reads 0. A command bit for a domain that is already busy is ignored and does not cause a second transition.
- R5: A command to an unpowered domain (domain status bits [1:0] = 0) whose next-on bit (domain control bit 0) is clear is ignored: busy and power request stay 0.
- R6: A command to an unpowered domain with next-on set raises power request bit d. No module of that domain changes or raises a request until power-good (domain control bit 8) is 1. A command to a powered domain raises no power request.
- R7: When a transition ends, power request bit d returns to 0, the power-good bit reads 0 again, and domain status bits [1:0] read 1.
- R8: A module whose force bit is clear and whose target differs from its state raises its request pin and changes state only after its acknowledge input has been seen high.
- R9: A module whose force bit (module control bit 31) is set reaches its target without raising its request pin.
- R10: Module status bits [1:0] hold the state, coded as SwRstDisable 0, SyncReset 1, Disable 2 and Enable 3. After a transition they equal the target held in module control bits [1:0].
- R11: Module status bit 12, and the clock-enable pin, read 1 exactly when the state is Enable or SyncReset.
- R12: Module control bit 8 is an active-low local reset. The reset pin and status bit 8 follow a write on the next cycle, without any command. The reset value is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid_i | input | 1 | Bus request valid |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata_o | output | 32 | Read data |
| pwr_req_o | output | N_DOM | External power request per domain |
| mod_req_o | output | N_MOD | State change request to each module |
| mod_ack_i | input | N_MOD | Acknowledge from each module |
| mod_lrst_n_o | output | N_MOD | Active-low local reset per module |
| mod_clk_en_o | output | N_MOD | Clock enable per module |

## Verification
Read data is due one cycle after the request edge. The bench's driver pushes each expected word into a queue when it issues a read, and a monitor pops the queue on read-valid, so every comparison is tied to the exact response slot. A local reset write is visible on the pin and in status one cycle after the write edge, and the bench checks it at the next falling edge. A transition ends a number of cycles after the command that depends on the power-good write and on the bench's acknowledge latency, so the bench polls the busy bit until it clears before it reads module status. It reads power request, module status and module request while the domain is still waiting, to show that nothing moves early.

// File: rtl/pd_sleep_pkg.sv
package pd_sleep_pkg;

  // module state encoding, shared by control target and status
  typedef enum logic [1:0] {
    MST_SWRSTDIS = 2'd0,
    MST_SYNCRST  = 2'd1,
    MST_DISABLE  = 2'd2,
    MST_ENABLE   = 2'd3
  } mod_state_e;

  typedef enum logic [1:0] {
    DS_IDLE  = 2'd0,
    DS_PWAIT = 2'd1,
    DS_APPLY = 2'd2
  } dom_seq_e;

  // register map (byte addresses, 4-byte stride in arrays)
  localparam int CMD_ADDR   = 'h120;
  localparam int BUSY_ADDR  = 'h128;
  localparam int PREQ_ADDR  = 'h1040;
  localparam int DSTAT_BASE = 'h200;
  localparam int DCTL_BASE  = 'h300;
  localparam int MSTAT_BASE = 'h800;
  localparam int MCTL_BASE  = 'hA00;

  // field positions
  localparam int NEXTON_BIT = 0;
  localparam int PGOOD_BIT  = 8;
  localparam int LRST_BIT   = 8;
  localparam int CLKON_BIT  = 12;
  localparam int FORCE_BIT  = 31;

  // fixed module-to-domain assignment: contiguous groups
  function automatic int dom_of(input int m, input int n_mod, input int n_dom);
    return (m * n_dom) / n_mod;
  endfunction

endpackage

// File: rtl/pd_dom_fsm.sv
module pd_dom_fsm
  import pd_sleep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic next_on_i,
  input  logic pgood_i,
  input  logic settled_i,
  output logic busy_o,
  output logic pwr_req_o,
  output logic pwr_on_o,
  output logic apply_o,
  output logic done_o
);

  dom_seq_e st_q;
  logic     busy_q, preq_q, pon_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= DS_IDLE;
      busy_q <= 1'b0;
      preq_q <= 1'b0;
      pon_q  <= 1'b0;
    end else begin
      case (st_q)
        DS_IDLE: begin
          if (start_i) begin
            if (pon_q) begin
              st_q   <= DS_APPLY;
              busy_q <= 1'b1;
            end else if (next_on_i) begin
              st_q   <= DS_PWAIT;
              busy_q <= 1'b1;
              preq_q <= 1'b1;
            end
          end
        end
        DS_PWAIT: begin
          if (pgood_i) begin
            pon_q <= 1'b1;
            st_q  <= DS_APPLY;
          end
        end
        DS_APPLY: begin
          if (settled_i) begin
            st_q   <= DS_IDLE;
            busy_q <= 1'b0;
            preq_q <= 1'b0;
          end
        end
        default: st_q <= DS_IDLE;
      endcase
    end
  end

  assign busy_o    = busy_q;
  assign pwr_req_o = preq_q;
  assign pwr_on_o  = pon_q;
  assign apply_o   = (st_q == DS_APPLY);
  assign done_o    = (st_q == DS_APPLY) && settled_i;

endmodule

// File: rtl/pd_mod_slot.sv
module pd_mod_slot
  import pd_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       apply_i,
  input  logic [1:0] tgt_i,
  input  logic       force_i,
  input  logic       ack_i,
  output logic [1:0] state_o,
  output logic       req_o,
  output logic       settled_o,
  output logic       clk_en_o
);

  logic [1:0] state_q;
  logic       req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MST_SWRSTDIS;
      req_q   <= 1'b0;
    end else if (apply_i && (state_q != tgt_i)) begin
      if (force_i) begin
        state_q <= tgt_i;
        req_q   <= 1'b0;
      end else if (req_q && ack_i) begin
        state_q <= tgt_i;
        req_q   <= 1'b0;
      end else begin
        req_q <= 1'b1;
      end
    end else begin
      req_q <= 1'b0;
    end
  end

  assign state_o   = state_q;
  assign req_o     = req_q;
  assign settled_o = (state_q == tgt_i);
  assign clk_en_o  = (state_q == MST_ENABLE) || (state_q == MST_SYNCRST);

endmodule

// File: rtl/pd_sleep_ctrl.sv
module pd_sleep_ctrl
  import pd_sleep_pkg::*;
#(
  parameter int N_DOM  = 2,
  parameter int N_MOD  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic              bus_rvalid_o,
  output logic [31:0]       bus_rdata_o,
  output logic [N_DOM-1:0]  pwr_req_o,
  output logic [N_MOD-1:0]  mod_req_o,
  input  logic [N_MOD-1:0]  mod_ack_i,
  output logic [N_MOD-1:0]  mod_lrst_n_o,
  output logic [N_MOD-1:0]  mod_clk_en_o
);

  logic                  wr_en;
  logic [N_DOM-1:0]      cmd_start;
  logic [N_DOM-1:0]      next_on_q, pg_q;
  logic [N_DOM-1:0]      busy_q, pwr_on, dom_apply, dom_done, dom_settled;
  logic [N_MOD-1:0][1:0] tgt_q, mst;
  logic [N_MOD-1:0]      force_q, lrst_q, settled;
  logic [31:0]           rd_next;
  logic                  unused_wdata;

  assign wr_en        = bus_valid_i && bus_write_i;
  assign cmd_start    = (wr_en && bus_addr_i == ADDR_W'(CMD_ADDR)) ?
                        bus_wdata_i[N_DOM-1:0] : '0;
  assign unused_wdata = ^bus_wdata_i;

  // domain control registers and sequencers
  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    always_ff @(posedge clk) begin
      if (rst) begin
        next_on_q[d] <= 1'b0;
        pg_q[d]      <= 1'b0;
      end else begin
        if (wr_en && bus_addr_i == ADDR_W'(DCTL_BASE + 4*d)) begin
          next_on_q[d] <= bus_wdata_i[NEXTON_BIT];
          pg_q[d]      <= bus_wdata_i[PGOOD_BIT];
        end
        if (dom_done[d]) pg_q[d] <= 1'b0;
      end
    end

    pd_dom_fsm u_seq (
      .clk       (clk),
      .rst       (rst),
      .start_i   (cmd_start[d]),
      .next_on_i (next_on_q[d]),
      .pgood_i   (pg_q[d]),
      .settled_i (dom_settled[d]),
      .busy_o    (busy_q[d]),
      .pwr_req_o (pwr_req_o[d]),
      .pwr_on_o  (pwr_on[d]),
      .apply_o   (dom_apply[d]),
      .done_o    (dom_done[d])
    );
  end

  // module control registers and state slots
  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    localparam int DOM = dom_of(m, N_MOD, N_DOM);

    always_ff @(posedge clk) begin
      if (rst) begin
        tgt_q[m]   <= MST_SWRSTDIS;
        force_q[m] <= 1'b0;
        lrst_q[m]  <= 1'b1;
      end else if (wr_en && bus_addr_i == ADDR_W'(MCTL_BASE + 4*m)) begin
        tgt_q[m]   <= bus_wdata_i[1:0];
        force_q[m] <= bus_wdata_i[FORCE_BIT];
        lrst_q[m]  <= bus_wdata_i[LRST_BIT];
      end
    end

    pd_mod_slot u_slot (
      .clk       (clk),
      .rst       (rst),
      .apply_i   (dom_apply[DOM]),
      .tgt_i     (tgt_q[m]),
      .force_i   (force_q[m]),
      .ack_i     (mod_ack_i[m]),
      .state_o   (mst[m]),
      .req_o     (mod_req_o[m]),
      .settled_o (settled[m]),
      .clk_en_o  (mod_clk_en_o[m])
    );
  end

  assign mod_lrst_n_o = lrst_q;

  // a domain is settled when each of its modules matches its target
  always_comb begin
    dom_settled = '1;
    for (int d = 0; d < N_DOM; d++) begin
      for (int m = 0; m < N_MOD; m++) begin
        if (dom_of(m, N_MOD, N_DOM) == d && !settled[m]) dom_settled[d] = 1'b0;
      end
    end
  end

  // read decode
  always_comb begin
    rd_next = '0;
    if (bus_addr_i == ADDR_W'(BUSY_ADDR)) rd_next = 32'(busy_q);
    if (bus_addr_i == ADDR_W'(PREQ_ADDR)) rd_next = 32'(pwr_req_o);
    for (int d = 0; d < N_DOM; d++) begin
      if (bus_addr_i == ADDR_W'(DSTAT_BASE + 4*d)) rd_next = {31'b0, pwr_on[d]};
      if (bus_addr_i == ADDR_W'(DCTL_BASE + 4*d))
        rd_next = {23'b0, pg_q[d], 7'b0, next_on_q[d]};
    end
    for (int m = 0; m < N_MOD; m++) begin
      if (bus_addr_i == ADDR_W'(MSTAT_BASE + 4*m))
        rd_next = {19'b0, mod_clk_en_o[m], 3'b0, lrst_q[m], 6'b0, mst[m]};
      if (bus_addr_i == ADDR_W'(MCTL_BASE + 4*m))
        rd_next = {force_q[m], 22'b0, lrst_q[m], 6'b0, tgt_q[m]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      bus_rvalid_o <= bus_valid_i && !bus_write_i;
      if (bus_valid_i && !bus_write_i) bus_rdata_o <= rd_next;
    end
  end

endmodule

// File: rtl/pd_sleep_ctrl_chk.sv
module pd_sleep_ctrl_chk
  import pd_sleep_pkg::*;
#(
  parameter int N_DOM  = 2,
  parameter int N_MOD  = 8,
  parameter int ADDR_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_valid_i,
  input logic                  bus_write_i,
  input logic [ADDR_W-1:0]     bus_addr_i,
  input logic [31:0]           bus_wdata_i,
  input logic                  bus_rvalid_o,
  input logic [N_DOM-1:0]      pwr_req_o,
  input logic [N_MOD-1:0]      mod_req_o,
  input logic [N_MOD-1:0]      mod_ack_i,
  input logic [N_MOD-1:0]      mod_lrst_n_o,
  input logic [N_DOM-1:0]      busy_q,
  input logic [N_DOM-1:0]      pg_q,
  input logic [N_MOD-1:0][1:0] mst,
  input logic [N_MOD-1:0]      force_q
);

  logic cmd_wr;
  assign cmd_wr = bus_valid_i && bus_write_i && bus_addr_i == ADDR_W'(CMD_ADDR);

  // R1
  rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_i && !bus_write_i) |=> bus_rvalid_o);

  for (genvar d = 0; d < N_DOM; d++) begin : g_d
    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_q[d]) |-> $past(cmd_wr && bus_wdata_i[d]));
    // R6
    preq_busy_chk: assert property (@(posedge clk) disable iff (rst)
      pwr_req_o[d] |-> busy_q[d]);
    // R7
    end_clean_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_q[d]) |-> (!pg_q[d] && !pwr_req_o[d]));
  end

  for (genvar m = 0; m < N_MOD; m++) begin : g_m
    localparam int DOM = dom_of(m, N_MOD, N_DOM);
    // R8
    req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
      mod_req_o[m] |-> busy_q[DOM]);
    // R3
    move_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (mst[m] != $past(mst[m])) |-> $past(busy_q[DOM]));
    // R8
    move_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
      ((mst[m] != $past(mst[m])) && !$past(force_q[m])) |-> $past(mod_ack_i[m]));
    // R12
    lrst_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_valid_i && bus_write_i && bus_addr_i == ADDR_W'(MCTL_BASE + 4*m))
      |=> (mod_lrst_n_o[m] == $past(bus_wdata_i[LRST_BIT])));
  end

endmodule

bind pd_sleep_ctrl pd_sleep_ctrl_chk #(
  .N_DOM (N_DOM),
  .N_MOD (N_MOD),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rvalid_o (bus_rvalid_o),
  .pwr_req_o    (pwr_req_o),
  .mod_req_o    (mod_req_o),
  .mod_ack_i    (mod_ack_i),
  .mod_lrst_n_o (mod_lrst_n_o),
  .busy_q       (busy_q),
  .pg_q         (pg_q),
  .mst          (mst),
  .force_q      (force_q)
);

// File: tb/pd_sleep_ctrl_bench.sv
module pd_sleep_ctrl_bench;

  localparam int N_DOM   = 2;
  localparam int N_MOD   = 8;
  localparam int ADDR_W  = 16;
  localparam int ACK_LAT = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_rvalid;
  logic [31:0]       bus_rdata;
  logic [N_DOM-1:0]  pwr_req;
  logic [N_MOD-1:0]  mod_req, mod_ack, mod_lrst_n, mod_clk_en;

  always #4 clk = ~clk;

  pd_sleep_ctrl #(.N_DOM(N_DOM), .N_MOD(N_MOD), .ADDR_W(ADDR_W)) u_pd_sleep_ctrl (
    .clk(clk), .rst(rst),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rvalid_o(bus_rvalid), .bus_rdata_o(bus_rdata),
    .pwr_req_o(pwr_req), .mod_req_o(mod_req), .mod_ack_i(mod_ack),
    .mod_lrst_n_o(mod_lrst_n), .mod_clk_en_o(mod_clk_en)
  );

  // module-side acknowledge model
  int hold [N_MOD];
  int req_seen [N_MOD];
  initial for (int m = 0; m < N_MOD; m++) begin hold[m] = 0; req_seen[m] = 0; end
  always @(posedge clk)
    for (int m = 0; m < N_MOD; m++) hold[m] <= mod_req[m] ? hold[m] + 1 : 0;
  always @(negedge clk)
    for (int m = 0; m < N_MOD; m++) if (mod_req[m]) req_seen[m]++;
  always_comb
    for (int m = 0; m < N_MOD; m++) mod_ack[m] = mod_req[m] && (hold[m] >= ACK_LAT);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] last_rd = '0;

  // scoreboard queues
  logic [31:0] q_exp [$];
  bit          q_chk [$];
  string       q_tag [$];

  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (q_exp.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1 unexpected read response act=%h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        bit c;
        string t;
        e = q_exp.pop_front(); c = q_chk.pop_front(); t = q_tag.pop_front();
        last_rd = bus_rdata;
        if (c) begin
          n_cmp++;
          if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd_exp(input int a, input logic [31:0] e, input string tag);
    q_exp.push_back(e); q_chk.push_back(1'b1); q_tag.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic rd_raw(input int a, output logic [31:0] v);
    q_exp.push_back('0); q_chk.push_back(1'b0); q_tag.push_back("");
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_valid = 1'b0;
    @(negedge clk);
    v = last_rd;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_idle(input int d, input string tag);
    logic [31:0] v;
    bit done = 0;
    for (int i = 0; i < 200 && !done; i++) begin
      rd_raw('h128, v);
      if (!v[d]) done = 1;
    end
    chk({tag, " busy clears"}, 32'(done), 32'd1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    rd_exp('h800, 32'h100, "R2 module0 status");
    rd_exp('h81C, 32'h100, "R2 module7 status");
    rd_exp('h200, 32'h0,   "R2 domain0 status");
    rd_exp('h128, 32'h0,   "R2 busy");
    rd_exp('h1040, 32'h0,  "R2 power request");
    chk("R2 no module request", 32'(mod_req), 32'h0);
    chk("R12 reset pin released", 32'(mod_lrst_n), 32'hFF);

    // R5 command to unpowered domain without next-on
    wr('h120, 32'h1);
    rd_exp('h128, 32'h0,  "R5 busy stays 0");
    rd_exp('h1040, 32'h0, "R5 no power request");

    // R3 target alone does nothing
    wr('h300, 32'h1);
    wr('hA00, 32'h103);
    rd_exp('h800, 32'h100, "R3 status unchanged without command");
    rd_exp('hA00, 32'h103, "R1 module0 control readback");

    // R6 power handshake
    wr('h120, 32'h1);
    rd_exp('h128, 32'h1,  "R4 busy set");
    rd_exp('h1040, 32'h1, "R6 power request raised");
    repeat (10) @(negedge clk);
    rd_exp('h800, 32'h100, "R6 module held before power good");
    chk("R6 no module request before power good", 32'(mod_req), 32'h0);
    wr('h300, 32'h101);
    wait_idle(0, "R4 domain0 power-up");
    rd_exp('h800, 32'h1103, "R10 module0 Enable");
    rd_exp('h1040, 32'h0,   "R7 power request cleared");
    rd_exp('h300, 32'h1,    "R7 power good auto-cleared");
    rd_exp('h200, 32'h1,    "R7 domain0 on");
    chk("R11 clock enable in Enable", 32'(mod_clk_en[0]), 32'd1);
    chk("R8 handshake used for module0", 32'(req_seen[0] > 0), 32'd1);

    // R4 busy ignore, R6 no request for powered domain, R8 acknowledge
    wr('hA04, 32'h103);
    wr('hA08, 32'h103);
    wr('h120, 32'h1);
    rd_exp('h1040, 32'h0, "R6 no power request for powered domain");
    rd_exp('h128, 32'h1,  "R4 busy during handshake");
    wr('h120, 32'h1);
    rd_exp('h804, 32'h100, "R8 module1 waits for acknowledge");
    wait_idle(0, "R8 domain0 two modules");
    repeat (3) @(negedge clk);
    rd_exp('h128, 32'h0,    "R4 repeated command not queued");
    rd_exp('h804, 32'h1103, "R10 module1 Enable");
    rd_exp('h808, 32'h1103, "R10 module2 Enable");

    // R9 force on domain1
    wr('h304, 32'h1);
    wr('hA10, 32'h8000_0101);
    wr('h120, 32'h2);
    wr('h304, 32'h101);
    wait_idle(1, "R9 domain1 forced");
    rd_exp('h810, 32'h1101, "R11 module4 SyncReset clocked");
    rd_exp('h204, 32'h1,    "R7 domain1 on");
    chk("R9 no request on forced module", 32'(req_seen[4]), 32'd0);
    rd_exp('h800, 32'h1103, "R3 domain0 unaffected by domain1 command");

    // R10 Disable and SwRstDisable
    wr('hA00, 32'h102);
    wr('hA04, 32'h100);
    wr('h120, 32'h1);
    wait_idle(0, "R10 domain0 disable");
    rd_exp('h800, 32'h102, "R10 module0 Disable");
    rd_exp('h804, 32'h100, "R10 module1 SwRstDisable");
    chk("R11 clock off in Disable", 32'(mod_clk_en[1:0]), 32'd0);

    // R12 local reset with no command
    wr('hA08, 32'h003);
    chk("R12 reset pin asserted", 32'(mod_lrst_n[2]), 32'd0);
    rd_exp('h808, 32'h1003, "R12 status reset bit low, state kept");
    rd_exp('h128, 32'h0,    "R12 no transition started");
    wr('hA08, 32'h103);
    chk("R12 reset pin released", 32'(mod_lrst_n[2]), 32'd1);

    repeat (4) @(negedge clk);
    chk("R1 all responses consumed", 32'(q_exp.size()), 32'd0);
    summary();
  end

endmodule